// File: doc/BRIEF.md
# BCD Clock-Calendar Timekeeping Counter

This block keeps wall-clock time and a calendar in packed BCD registers: seconds, minutes, hours, day of the week, date, month and a two-digit year. A one-cycle strobe that arrives once per second advances the time. Every rollover, from seconds up to the year, settles in the same clock cycle as the strobe. The hours register carries its own format: one bit chooses 12-hour or 24-hour counting. In 12-hour form a second bit is the PM flag. In 24-hour form that same bit is the upper tens digit.

Software loads any single field through a select-and-data write port. All seven fields are presented continuously on parallel read outputs. A halt input freezes timekeeping without disturbing the stored values. The date wraps according to the month length, and February gets a 29th day in every year whose two-digit value is a multiple of four. The one-second strobe comes from outside the block.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour form), day of week 01, date 01, month 01 and year 00.
- R2: A write with `wr_en`=1 loads the field chosen by `wr_sel`. The codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. Bits with no meaning are forced to 0: seconds and minutes keep bits 6:0, hours keeps bits 6:0, day of week keeps bits 2:0, date keeps bits 5:0, month keeps bits 4:0, and year keeps all eight bits. Code 7 changes nothing.
- R3: Each accepted tick adds one to the seconds. Seconds wrap from 59 to 00 and carry into the minutes. Minutes wrap from 59 to 00 and carry into the hours.
- R4: In 24-hour form (hours bit 6 = 0), bits 5:4 hold the tens digit and hours count 00 to 23. A carry out of 23 returns the hours to 00 and advances the day.
- R5: In 12-hour form (hours bit 6 = 1), bit 5 is the PM flag (1 = PM), bit 4 is the tens digit, and hours count 01 to 12. Going from 11 to 12 toggles the flag. Going from 12 to 01 leaves the flag unchanged. The day advances only on the step from 11 PM to 12 AM. A tick never changes bit 6.
- R6: On a day advance the date wraps to 01 and the month advances after date 30 in months 04, 06, 09 and 11, and after date 31 in the other months except February. Month wraps from 12 to 01.
- R7: February ends after date 29 when the year value is divisible by four, 00 included. Otherwise it ends after date 28.
- R8: Each day advance also steps the day of week, wrapping from 7 to 1.
- R9: A month carry out of 12 advances the year, and the year wraps from 99 to 00. A tick at 23:59:59 on 31 December of year 99 updates every field in one cycle.
- R10: While `halt`=1 a tick changes no field.
- R11: When a write and a tick arrive in the same cycle, the write takes effect and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| halt | input | 1 | 1 stops timekeeping, 0 lets it run |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select code for the write |
| wr_data | input | 8 | BCD value to write |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, with mode and PM/tens bits |
| wday_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |

## Verification
The assertions check, on every cycle, the properties that can be stated locally:
- Unused bits stay 0.
- Nothing moves without an accepted tick, or while halted.
- A write lands its masked value one cycle later.
- The hours mode bit changes only through a write.
- Seconds below 59 never disturb higher fields.
- Seconds at 59 return to 00.

The calendar outcomes need full starting times, so only the bench scenarios show them. These outcomes are the month lengths, the leap-year February, the 12-hour PM sequence, the day-of-week wrap and the all-fields year-end cascade.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int FIELD_W = 8;
    localparam int SEL_W   = 3;

    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] wday;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] year;
    } cal_regs_t;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } fld_sel_t;

    // Write masks: bits outside a field's BCD range are held at zero.
    localparam logic [FIELD_W-1:0] MASK_SEC   = 8'h7F;
    localparam logic [FIELD_W-1:0] MASK_MIN   = 8'h7F;
    localparam logic [FIELD_W-1:0] MASK_HOUR  = 8'h7F;
    localparam logic [FIELD_W-1:0] MASK_WDAY  = 8'h07;
    localparam logic [FIELD_W-1:0] MASK_DATE  = 8'h3F;
    localparam logic [FIELD_W-1:0] MASK_MONTH = 8'h1F;
    localparam logic [FIELD_W-1:0] MASK_YEAR  = 8'hFF;

    // Add one to a two-digit packed BCD value.
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        logic [FIELD_W-1:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_bcd_roll.sv
module cal_bcd_roll
    import cal_pkg::*;
#(
    parameter logic [FIELD_W-1:0] LO = 8'h00,
    parameter logic [FIELD_W-1:0] HI = 8'h59
) (
    input  logic [FIELD_W-1:0] cur,
    input  logic               step,
    output logic [FIELD_W-1:0] nxt,
    output logic               carry
);

    always_comb begin
        nxt   = cur;
        carry = 1'b0;
        if (step) begin
            if (cur == HI) begin
                nxt   = LO;
                carry = 1'b1;
            end else begin
                nxt = bcd_inc(cur);
            end
        end
    end

endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
    import cal_pkg::*;
(
    input  logic [FIELD_W-1:0] cur,
    input  logic               step,
    output logic [FIELD_W-1:0] nxt,
    output logic               carry
);

    logic [FIELD_W-1:0] h12;
    logic [FIELD_W-1:0] h12_inc;
    logic [FIELD_W-1:0] h24;

    assign h12     = {3'b000, cur[4:0]};
    assign h12_inc = bcd_inc(h12);
    assign h24     = {2'b00, cur[5:0]};

    always_comb begin
        nxt   = cur;
        carry = 1'b0;
        if (step) begin
            if (cur[6]) begin
                if (h12 == 8'h11) begin
                    // 11 -> 12 flips the meridiem; PM -> AM starts a new day
                    nxt   = {2'b01, ~cur[5], 5'h12};
                    carry = cur[5];
                end else if (h12 == 8'h12) begin
                    nxt = {2'b01, cur[5], 5'h01};
                end else begin
                    nxt = 8'h40 | {2'b00, cur[5], 5'b00000} | (h12_inc & 8'h1F);
                end
            end else begin
                if (h24 == 8'h23) begin
                    nxt   = 8'h00;
                    carry = 1'b1;
                end else begin
                    nxt = bcd_inc(h24);
                end
            end
        end
    end

endmodule

// File: rtl/cal_month_end.sv
module cal_month_end
    import cal_pkg::*;
(
    input  logic [FIELD_W-1:0] month,
    input  logic [FIELD_W-1:0] year,
    output logic [FIELD_W-1:0] last_date
);

    logic [FIELD_W-1:0] year_bin;
    logic               leap;

    assign year_bin = ({4'b0000, year[7:4]} * 8'd10) + {4'b0000, year[3:0]};
    assign leap     = (year_bin & 8'h03) == 8'h00;

    always_comb begin
        case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
    import cal_pkg::*;
#(
    parameter logic [7:0] INIT_WDAY  = 8'h01,
    parameter logic [7:0] INIT_DATE  = 8'h01,
    parameter logic [7:0] INIT_MONTH = 8'h01,
    parameter logic [7:0] INIT_YEAR  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       halt,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);

    localparam int NUM_MS = 2;

    cal_regs_t regs_q, regs_d;

    logic               tick_go;
    logic [NUM_MS:0]    ms_step;
    logic [FIELD_W-1:0] ms_cur [NUM_MS];
    logic [FIELD_W-1:0] ms_nxt [NUM_MS];
    logic [FIELD_W-1:0] hour_nxt, wday_nxt, month_nxt, year_nxt;
    logic [FIELD_W-1:0] last_date;
    logic               day_step, month_step, year_step;
    logic               wday_unused, year_unused;

    // A write in the same cycle swallows the tick.
    assign tick_go    = sec_tick & ~halt & ~wr_en;
    assign ms_step[0] = tick_go;
    assign ms_cur[0]  = regs_q.sec;
    assign ms_cur[1]  = regs_q.min;

    generate
        for (genvar i = 0; i < NUM_MS; i++) begin : g_minsec
            cal_bcd_roll #(.LO(8'h00), .HI(8'h59)) u_roll (
                .cur   (ms_cur[i]),
                .step  (ms_step[i]),
                .nxt   (ms_nxt[i]),
                .carry (ms_step[i+1])
            );
        end
    endgenerate

    cal_hour_step u_hour (
        .cur   (regs_q.hour),
        .step  (ms_step[NUM_MS]),
        .nxt   (hour_nxt),
        .carry (day_step)
    );

    cal_bcd_roll #(.LO(8'h01), .HI(8'h07)) u_wday (
        .cur   (regs_q.wday),
        .step  (day_step),
        .nxt   (wday_nxt),
        .carry (wday_unused)
    );

    cal_month_end u_mend (
        .month     (regs_q.month),
        .year      (regs_q.year),
        .last_date (last_date)
    );

    assign month_step = day_step && (regs_q.date == last_date);

    cal_bcd_roll #(.LO(8'h01), .HI(8'h12)) u_month (
        .cur   (regs_q.month),
        .step  (month_step),
        .nxt   (month_nxt),
        .carry (year_step)
    );

    cal_bcd_roll #(.LO(8'h00), .HI(8'h99)) u_year (
        .cur   (regs_q.year),
        .step  (year_step),
        .nxt   (year_nxt),
        .carry (year_unused)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (fld_sel_t'(wr_sel))
                FLD_SEC:   regs_d.sec   = wr_data & MASK_SEC;
                FLD_MIN:   regs_d.min   = wr_data & MASK_MIN;
                FLD_HOUR:  regs_d.hour  = wr_data & MASK_HOUR;
                FLD_WDAY:  regs_d.wday  = wr_data & MASK_WDAY;
                FLD_DATE:  regs_d.date  = wr_data & MASK_DATE;
                FLD_MONTH: regs_d.month = wr_data & MASK_MONTH;
                FLD_YEAR:  regs_d.year  = wr_data & MASK_YEAR;
                default:   regs_d = regs_q;
            endcase
        end else begin
            regs_d.sec   = ms_nxt[0];
            regs_d.min   = ms_nxt[1];
            regs_d.hour  = hour_nxt;
            regs_d.wday  = wday_nxt;
            regs_d.month = month_nxt;
            regs_d.year  = year_nxt;
            if (day_step) begin
                regs_d.date = (regs_q.date == last_date) ? 8'h01 : bcd_inc(regs_q.date);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: INIT_WDAY,
                        date: INIT_DATE, month: INIT_MONTH, year: INIT_YEAR};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sec_o   = regs_q.sec;
    assign min_o   = regs_q.min;
    assign hour_o  = regs_q.hour;
    assign wday_o  = regs_q.wday;
    assign date_o  = regs_q.date;
    assign month_o = regs_q.month;
    assign year_o  = regs_q.year;

endmodule

// File: rtl/cal_core_checker.sv
module cal_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       halt,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o
);

    logic [55:0] all_f;
    assign all_f = {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};

    // R2: unused high bits never read as one
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[7] == 1'b0) && (min_o[7] == 1'b0) && (hour_o[7] == 1'b0) &&
        (wday_o[7:3] == 5'd0) && (date_o[7:6] == 2'd0) && (month_o[7:5] == 3'd0));

    // R2: a seconds write lands masked one cycle later
    assert_sec_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0) |=> (sec_o == ($past(wr_data) & 8'h7F)));

    // R2: select code 7 leaves every field alone
    assert_null_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd7) |=> $stable(all_f));

    // R10: halted and no write means nothing moves
    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en) |=> $stable(all_f));

    // R11: with no tick and no write, all fields hold
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !wr_en) |=> $stable(all_f));

    // R3: a tick below 59 seconds leaves the higher fields alone
    assert_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !halt && !wr_en && sec_o != 8'h59) |=>
        ($stable(min_o) && $stable(hour_o) && $stable(date_o) && !$stable(sec_o)));

    // R3: seconds at 59 wrap to zero
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !halt && !wr_en && sec_o == 8'h59) |=> (sec_o == 8'h00));

    // R5: only an hours write may change the 12/24 mode bit
    assert_mode_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 3'd2) |=> $stable(hour_o[6]));

endmodule

bind bcd_calendar_core cal_core_checker u_cal_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec_tick(sec_tick),
    .halt    (halt),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .sec_o   (sec_o),
    .min_o   (min_o),
    .hour_o  (hour_o),
    .wday_o  (wday_o),
    .date_o  (date_o),
    .month_o (month_o),
    .year_o  (year_o)
);

// File: tb/bcd_calendar_core_bench.sv
`timescale 1ns/1ps
module bcd_calendar_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       halt = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar_core u_bcd_calendar_core (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .halt(halt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    // {req tag, start fields, expected fields}; bytes: sec,min,hour,wday,date,month,year
    localparam int NV = 19;
    localparam logic [119:0] VEC [NV] = '{
        {8'd3, 56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00},
        {8'd3, 56'h59_12_05_02_10_06_25, 56'h00_13_05_02_10_06_25},
        {8'd9, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},
        {8'd4, 56'h59_59_09_04_10_06_25, 56'h00_00_10_04_10_06_25},
        {8'd4, 56'h59_59_19_04_10_06_25, 56'h00_00_20_04_10_06_25},
        {8'd5, 56'h59_59_51_02_10_06_25, 56'h00_00_72_02_10_06_25},
        {8'd5, 56'h59_59_72_02_10_06_25, 56'h00_00_61_02_10_06_25},
        {8'd5, 56'h59_59_71_03_15_06_25, 56'h00_00_52_04_16_06_25},
        {8'd5, 56'h59_59_52_04_16_06_25, 56'h00_00_41_04_16_06_25},
        {8'd6, 56'h59_59_23_02_30_04_25, 56'h00_00_00_03_01_05_25},
        {8'd6, 56'h59_59_23_02_30_11_25, 56'h00_00_00_03_01_12_25},
        {8'd6, 56'h59_59_23_06_30_03_25, 56'h00_00_00_07_31_03_25},
        {8'd7, 56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
        {8'd7, 56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
        {8'd7, 56'h59_59_23_02_29_02_24, 56'h00_00_00_03_01_03_24},
        {8'd7, 56'h59_59_23_02_28_02_00, 56'h00_00_00_03_29_02_00},
        {8'd7, 56'h59_59_23_02_28_02_10, 56'h00_00_00_03_01_03_10},
        {8'd8, 56'h59_59_23_07_31_07_25, 56'h00_00_00_01_01_08_25},
        {8'd9, 56'h59_59_23_02_31_12_25, 56'h00_00_00_03_01_01_26}
    };

    function automatic logic [55:0] fields();
        return {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
    endfunction

    task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; sec_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic load(input logic [55:0] f);
        for (int k = 0; k < 7; k++) begin
            wr(3'(k), f[55-8*k -: 8], 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1", fields(), 56'h00_00_00_01_01_01_00);

        // R3 R4 R5 R6 R7 R8 R9: tick from each start time
        for (int v = 0; v < NV; v++) begin
            load(VEC[v][111:56]);
            tick();
            check($sformatf("R%0d vec%0d", VEC[v][119:112], v), fields(), VEC[v][55:0]);
        end

        // R10: halted tick changes nothing
        load(56'h30_15_08_02_10_06_25);
        halt = 1'b1;
        tick();
        tick();
        check("R10", fields(), 56'h30_15_08_02_10_06_25);
        halt = 1'b0;
        tick();
        check("R10 resume", fields(), 56'h31_15_08_02_10_06_25);

        // R11: write wins over a same-cycle tick
        wr(3'd0, 8'h45, 1'b1);
        check("R11 sec", fields(), 56'h45_15_08_02_10_06_25);
        load(56'h59_59_23_02_10_06_25);
        wr(3'd1, 8'h20, 1'b1);
        check("R11 cascade", fields(), 56'h59_20_23_02_10_06_25);

        // R2: masking of unused bits and the null select code
        wr(3'd3, 8'hFF, 1'b0);
        check("R2 wday mask", {24'h0, wday_o, 24'h0}, {24'h0, 8'h07, 24'h0});
        wr(3'd4, 8'hFF, 1'b0);
        check("R2 date mask", {32'h0, date_o, 16'h0}, {32'h0, 8'h3F, 16'h0});
        wr(3'd5, 8'hF2, 1'b0);
        check("R2 month mask", {40'h0, month_o, 8'h0}, {40'h0, 8'h12, 8'h0});
        wr(3'd0, 8'hD9, 1'b0);
        check("R2 sec mask", {sec_o, 48'h0}, {8'h59, 48'h0});
        wr(3'd7, 8'h00, 1'b0);
        check("R2 null sel", fields(), 56'h59_20_23_07_3F_12_25);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule